// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block is the digital front end of a 16-bit string converter with a voltage output. A host writes 24-bit frames over three wires: an active-low frame select, a serial clock and a data line. The block runs on a faster system clock. It brings the frame select, the serial clock and the data line into that domain through two-flop chains. It shifts in one data bit on each falling edge of the serial clock, and on the last bit of a frame it loads a 16-bit code and a 2-bit output-stage mode together.

The host sends codes in two's complement. The converter needs offset binary, so the block drives the stored code with its sign bit inverted. The mode field chooses how the output stage is set: driven by the amplifier, pulled to ground through about 1 kΩ, pulled to ground through about 100 kΩ, or left floating. If the frame select rises before the last bit arrives, the frame is dropped with no side effects. After reset the output sits at midscale with the amplifier driving. Two single-cycle strobes report a code write and a mode change.

Top module: `sdac_frame_rx`

## Requirements
- R1: After reset, code_o is 16'h8000 (midscale), stage_o is 2'b00 and neither strobe pulses until a complete frame is received.
- R2: A frame is 24 bits, most significant bit first, sampled on serial clock falling edges while sync_n_i is low. Bits 23..18 are ignored, bits 17..16 are the mode field and bits 15..0 are the two's-complement code.
- R3: On the 24th falling edge, the code register and the mode register are both written. code_upd_o pulses for exactly one system clock in the same cycle that the new values appear.
- R4: If sync_n_i goes high before the 24th falling edge, the partial frame is discarded. code_o and stage_o keep their values, no strobe pulses, and the next full frame loads correctly.
- R5: stage_o equals the received mode field: 2'b00 amplifier drives, 2'b01 about 1 kΩ to ground, 2'b10 about 100 kΩ to ground, 2'b11 floating.
- R6: Every complete frame loads its code, whatever its mode field. While a power-down mode is held, code_o keeps the last loaded code, and it is still present when the mode returns to 2'b00.
- R7: code_o is the stored two's-complement code with bit 15 inverted: -32768 gives 16'h0000, -1 gives 16'h7FFF, +32767 gives 16'hFFFF.
- R8: After 24 bits have been taken, further serial clock falling edges in the same low period of sync_n_i change nothing.
- R9: A new frame starts only when sync_n_i goes high and then falls again. A frame sent after such a rise and fall loads normally.
- R10: mode_upd_o pulses for one cycle, together with code_upd_o, only when a frame writes a mode that differs from the stored mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n_i | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock; data taken on its falling edge |
| din_i | input | 1 | Serial data, most significant bit first |
| code_o | output | 16 | Offset-binary code to the converter |
| stage_o | output | 2 | Output-stage selection |
| code_upd_o | output | 1 | One-cycle pulse on every code register write |
| mode_upd_o | output | 1 | One-cycle pulse when the mode value changes |

## Verification
A bit counter off by one shows at code_o as a code shifted by one position, or as a frame that never loads. In both cases code_upd_o is missing or early, and this is seen a few system clocks after the 24th serial edge. The tests use codes with asymmetric bit patterns and ones in the ignored bits so that such shifts are caught. A shift register that is not cleared, or a frame that is not cancelled on an early rise, shows up as a change at code_o or stage_o, or a stray strobe, after an aborted or over-long frame. Each such case is checked before the next valid frame is sent.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int CODE_W  = 16;
  localparam int MODE_W  = 2;
  localparam int FRAME_W = 24;

  typedef enum logic [1:0] {
    STG_DRIVE = 2'b00,
    STG_R1K   = 2'b01,
    STG_R100K = 2'b10,
    STG_HIZ   = 2'b11
  } stage_e;
endpackage

// File: rtl/sdac_sync_chain.sv
module sdac_sync_chain #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic d;
    if (g == 0) begin : g_first
      assign d = a_i;
    end else begin : g_next
      assign d = chain_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= RST_VAL;
      else        chain_q[g] <= d;
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdac_frame_shift.sv
module sdac_frame_shift #(
  parameter int CODE_W  = 16,
  parameter int MODE_W  = 2,
  parameter int FRAME_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_lvl_i,
  input  logic              sclk_lvl_i,
  input  logic              din_lvl_i,
  output logic              load_o,
  output logic [CODE_W-1:0] code_o,
  output logic [MODE_W-1:0] mode_o
);
  localparam int PAY_W = CODE_W + MODE_W;
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic             sync_hist_q, sclk_hist_q;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PAY_W-2:0] sh_q, sh_d;
  logic             sync_fall, sclk_fall;
  logic [PAY_W-1:0] word;

  assign sync_fall = sync_hist_q & ~sync_lvl_i;
  assign sclk_fall = sclk_hist_q & ~sclk_lvl_i;
  assign word      = {sh_q, din_lvl_i};
  assign code_o    = word[CODE_W-1:0];
  assign mode_o    = word[PAY_W-1:CODE_W];

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    load_o  = 1'b0;
    if (sync_lvl_i) begin
      armed_d = 1'b0;
      cnt_d   = '0;
      sh_d    = '0;
    end else if (sync_fall) begin
      armed_d = 1'b1;
      cnt_d   = '0;
      sh_d    = '0;
    end else if (armed_q && sclk_fall && (cnt_q != FULL)) begin
      sh_d   = word[PAY_W-2:0];
      cnt_d  = cnt_q + 1'b1;
      load_o = (cnt_q == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_hist_q <= 1'b1;
      sclk_hist_q <= 1'b0;
      armed_q     <= 1'b0;
      cnt_q       <= '0;
      sh_q        <= '0;
    end else begin
      sync_hist_q <= sync_lvl_i;
      sclk_hist_q <= sclk_lvl_i;
      armed_q     <= armed_d;
      cnt_q       <= cnt_d;
      sh_q        <= sh_d;
    end
  end

  // R4: no load while the frame select is high
  a_r4_no_load_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lvl_i |-> !load_o);
  // R8: a filled frame accepts no further load
  a_r8_no_load_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL) |-> !load_o);
  // R9: a load only happens inside an armed frame
  a_r9_load_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> armed_q);
endmodule

// File: rtl/sdac_out_regs.sv
module sdac_out_regs #(
  parameter int CODE_W = 16,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              code_upd_o,
  output logic              mode_upd_o
);
  logic [CODE_W-1:0] dac_q, dac_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              cupd_d, mupd_d;

  always_comb begin
    dac_d  = dac_q;
    mode_d = mode_q;
    cupd_d = 1'b0;
    mupd_d = 1'b0;
    if (load_i) begin
      dac_d  = code_i;
      mode_d = mode_i;
      cupd_d = 1'b1;
      mupd_d = (mode_i != mode_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q      <= '0;
      mode_q     <= '0;
      code_upd_o <= 1'b0;
      mode_upd_o <= 1'b0;
    end else begin
      dac_q      <= dac_d;
      mode_q     <= mode_d;
      code_upd_o <= cupd_d;
      mode_upd_o <= mupd_d;
    end
  end

  assign dac_code_o = {~dac_q[CODE_W-1], dac_q[CODE_W-2:0]};
  assign mode_o     = mode_q;

  // R3: the code register changes only on a load
  a_r3_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(dac_q));
  // R4: the mode register changes only on a load
  a_r4_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(mode_q));
  // R10: a mode strobe comes with a code strobe
  a_r10_mode_strobe_pair: assert property (@(posedge clk) disable iff (!rst_n)
    mode_upd_o |-> code_upd_o);
  // R10: a mode strobe means the mode value moved
  a_r10_mode_strobe_change: assert property (@(posedge clk) disable iff (!rst_n)
    mode_upd_o |-> (mode_q != $past(mode_q)));
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
  import sdac_pkg::*;
#(
  parameter int C_W     = CODE_W,
  parameter int M_W     = MODE_W,
  parameter int F_W     = FRAME_W,
  parameter int SYNC_FF = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sync_n_i,
  input  logic           sclk_i,
  input  logic           din_i,
  output logic [C_W-1:0] code_o,
  output logic [M_W-1:0] stage_o,
  output logic           code_upd_o,
  output logic           mode_upd_o
);
  logic           sync_lvl, sclk_lvl, din_lvl, load;
  logic [C_W-1:0] rx_code;
  logic [M_W-1:0] rx_mode;

  sdac_sync_chain #(.STAGES(SYNC_FF), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .a_i(sync_n_i), .q_o(sync_lvl));
  sdac_sync_chain #(.STAGES(SYNC_FF), .RST_VAL(1'b0)) u_sclk (
    .clk(clk), .rst_n(rst_n), .a_i(sclk_i), .q_o(sclk_lvl));
  sdac_sync_chain #(.STAGES(SYNC_FF), .RST_VAL(1'b0)) u_din (
    .clk(clk), .rst_n(rst_n), .a_i(din_i), .q_o(din_lvl));

  sdac_frame_shift #(.CODE_W(C_W), .MODE_W(M_W), .FRAME_W(F_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sync_lvl_i(sync_lvl), .sclk_lvl_i(sclk_lvl),
    .din_lvl_i(din_lvl), .load_o(load), .code_o(rx_code), .mode_o(rx_mode));

  sdac_out_regs #(.CODE_W(C_W), .MODE_W(M_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .load_i(load), .code_i(rx_code), .mode_i(rx_mode),
    .dac_code_o(code_o), .mode_o(stage_o), .code_upd_o(code_upd_o),
    .mode_upd_o(mode_upd_o));

  // R5: the output stage only moves together with a write strobe
  a_r5_stage_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !code_upd_o |-> (stage_o == $past(stage_o) || $past(!rst_n)));
endmodule

// File: tb/sdac_frame_rx_tb.sv
module sdac_frame_rx_tb_top;
  import sdac_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic [15:0] code_o;
  logic [1:0]  stage_o;
  logic        code_upd_o, mode_upd_o;

  int n_chk = 0;
  int n_fail = 0;
  int n_cupd = 0;
  int n_mupd = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdac_frame_rx dut_i (
    .clk(clk), .rst_n(rst_n), .sync_n_i(sync_n), .sclk_i(sclk), .din_i(din),
    .code_o(code_o), .stage_o(stage_o), .code_upd_o(code_upd_o),
    .mode_upd_o(mode_upd_o));

  always @(negedge clk) begin
    if (rst_n) begin
      n_cupd += int'(code_upd_o);
      n_mupd += int'(mode_upd_o);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges(input logic [23:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      din = w[23-i];
      sclk = 1'b1;
      wclk(4);
      sclk = 1'b0;
      wclk(4);
    end
  endtask

  task automatic frame(input logic [1:0] m, input logic [15:0] c, input int n, input bit stay_low);
    sync_n = 1'b0;
    wclk(4);
    edges({6'h3F, m, c}, n);
    wclk(6);
    if (!stay_low) begin
      sync_n = 1'b1;
      wclk(6);
    end
  endtask

  task automatic t_reset;
    chk("R1 code", int'(code_o), 'h8000);
    chk("R1 stage", int'(stage_o), 0);
    chk("R1 strobes", n_cupd + n_mupd, 0);
  endtask

  task automatic t_basic;
    int c0 = n_cupd, m0 = n_mupd;
    frame(2'b00, 16'h1234, 24, 0);
    chk("R2/R7 code", int'(code_o), 'h9234);
    chk("R2 stage", int'(stage_o), 0);
    chk("R3 code strobe", n_cupd - c0, 1);
    chk("R10 no mode strobe", n_mupd - m0, 0);
  endtask

  task automatic t_signs;
    frame(2'b00, 16'h8000, 24, 0);
    chk("R7 most negative", int'(code_o), 'h0000);
    frame(2'b00, 16'h7FFF, 24, 0);
    chk("R7 most positive", int'(code_o), 'hFFFF);
    frame(2'b00, 16'hFFFF, 24, 0);
    chk("R7 minus one", int'(code_o), 'h7FFF);
  endtask

  task automatic t_modes;
    int m0;
    for (int m = 1; m < 4; m++) begin
      m0 = n_mupd;
      frame(m[1:0], 16'h0100, 24, 0);
      chk("R5 stage", int'(stage_o), m);
      chk("R10 mode strobe", n_mupd - m0, 1);
      chk("R6 code in power-down", int'(code_o), 'h8100);
    end
    m0 = n_mupd;
    frame(STG_HIZ, 16'h0200, 24, 0);
    chk("R10 same mode no strobe", n_mupd - m0, 0);
    chk("R6 code kept", int'(code_o), 'h8200);
    frame(STG_DRIVE, 16'h0200, 24, 0);
    chk("R6 back to drive stage", int'(stage_o), int'(STG_DRIVE));
    chk("R6 back to drive code", int'(code_o), 'h8200);
  endtask

  task automatic t_abort;
    int c0 = n_cupd, m0 = n_mupd;
    frame(2'b10, 16'h5555, 23, 0);
    chk("R4 code unchanged", int'(code_o), 'h8200);
    chk("R4 stage unchanged", int'(stage_o), 0);
    chk("R4 no strobe", (n_cupd - c0) + (n_mupd - m0), 0);
    frame(2'b01, 16'h0001, 24, 0);
    chk("R4 next frame code", int'(code_o), 'h8001);
    chk("R4 next frame stage", int'(stage_o), 1);
  endtask

  task automatic t_stay_low;
    int c0;
    frame(2'b00, 16'h0AAA, 24, 1);
    c0 = n_cupd;
    edges(24'hFF7777, 24);
    wclk(6);
    chk("R8 code after extra edges", int'(code_o), 'h8AAA);
    chk("R8 stage after extra edges", int'(stage_o), 0);
    chk("R8 no strobe", n_cupd - c0, 0);
    sync_n = 1'b1;
    wclk(6);
    frame(2'b00, 16'h1111, 24, 0);
    chk("R9 new frame after rise", int'(code_o), 'h9111);
  endtask

  initial begin
    wclk(3);
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_basic();
    t_signs();
    t_modes();
    t_abort();
    t_stay_low();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule